// File: doc/BRIEF.md
# Multi-Queue Transmit Scheduler Register File

This block holds the control state of a transmit scheduler that feeds sixteen frame queues into eight DMA FIFO channels. Each queue owns an 8-bit write index, an 8-bit read index and a 10-bit status word. The status word says whether the queue is active and which channel it feeds. Three shared words complete the state: a per-channel enable mask, a per-queue chain-mode select and a per-queue empty flag. Software reaches all of them through a simple word-addressed write port and a combinational read port.

Every cycle the block offers one frame. It picks an active queue with a frame waiting, whose channel is enabled and whose channel reports ready. The choice appears on `sel_valid`, `sel_queue` and `sel_fifo`. A frame offered at a clock edge is taken at that edge, and the queue's read index moves forward by one. Queues are drained strictly in order, one frame per grant.

The status word and the empty word carry their own write-enable masks, so one write can change a single field without a read-modify-write. Channels 3, 2, 1 and 0 are served first, in that order. Channels 4 to 7 follow in fixed order. Queues that share a channel take turns by queue number.

Top module: `txq_sched_regs`

## Requirements
- R1: After reset all write and read indexes, status words, the channel enable mask and the chain select read as zero, the empty word reads 0xFFFF, and `sel_valid` is low.
- R2: Word addresses 0x00+q hold queue q's write index and 0x10+q its read index, both 8 bits. Address 0x20+q holds its status word, 0x30 the channel enable mask (bit c for channel c), 0x31 the chain select (bit q) and 0x32 the empty word. Each reads back what was written, zero-extended to 32 bits.
- R3: In a status write, data bit 10+k enables bit k for k in 0..9. Bits without their enable keep their value, and data bits 31:20 have no effect. Status bit 0 is active, bits 4:1 the channel number and bit 8 the acknowledge-mode flag.
- R4: In a write to the empty word, data bit 16+q enables empty bit q, which takes data bit q. 1 means empty.
- R5: When a queue's write index or read index is written or advanced, its empty bit becomes (write index == read index) in the same update. This takes precedence over a masked write to the empty word in that cycle.
- R6: A queue is eligible only when it is active, its empty bit is 0, its channel number is below 8, that channel's enable bit is 1 and its `fifo_ready` bit is 1. A status write to an inactive queue still updates the enabled fields, but the queue is never offered.
- R7: A frame offered at a clock edge advances that queue's read index by one, modulo 256, at the same edge. A register write to that read index in the same cycle wins.
- R8: Among eligible queues, the winning channel is the first present in the order 3, 2, 1, 0, 4, 5, 6, 7.
- R9: Within the winning channel, the offered queue is the first eligible one in ascending queue number after the queue last granted on that channel, wrapping at 15. The record of the last grant on each channel starts at 15 after reset.
- R10: The chain-select bits and the acknowledge-mode bit are stored and read back, but do not change service. Such a queue is still drained one frame per grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 32 | Write data, including the embedded masks |
| rd_addr | input | 6 | Word address of the read |
| rd_data | output | 32 | Register contents at `rd_addr`, combinational |
| fifo_ready | input | 8 | Per-channel readiness to accept a frame |
| sel_valid | output | 1 | A frame is offered and is taken at the next edge |
| sel_queue | output | 4 | Queue of the offered frame |
| sel_fifo | output | 3 | Channel of the offered frame |

## Verification
The assertions take for granted that every offered frame is consumed at the edge where it is offered. They also assume software does not write a queue's read index in the same cycle that the queue is offered, except when the bench does so on purpose to exercise R7; the advance assertion is gated off during any write. The bench holds `fifo_ready` high for exactly one clock per intended grant, except in the multi-frame drain tests. It issues register writes only on falling edges, so every write and every grant lands on a known edge.

// File: rtl/txq_sched_regs.sv
module txq_sched_regs #(
  parameter int NQ    = 16,
  parameter int NF    = 8,
  parameter int NEDCA = 4,
  parameter int PW    = 8,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [NF-1:0] fifo_ready,
  output logic          sel_valid,
  output logic [$clog2(NQ)-1:0] sel_queue,
  output logic [$clog2(NF)-1:0] sel_fifo
);
  localparam int QW = $clog2(NQ);
  localparam int FW = $clog2(NF);
  localparam int SW = 10;
  localparam int WP_BASE = 0;
  localparam int RP_BASE = NQ;
  localparam int ST_BASE = 2 * NQ;
  localparam int A_FACT  = 3 * NQ;
  localparam int A_CHAIN = 3 * NQ + 1;
  localparam int A_EMPTY = 3 * NQ + 2;

  logic [PW-1:0] wp [NQ];
  logic [PW-1:0] rp [NQ];
  logic [SW-1:0] st [NQ];
  logic [QW-1:0] last [NF];
  logic [NF-1:0] fact;
  logic [NQ-1:0] chain, empty;

  logic [PW-1:0] wp_n [NQ];
  logic [PW-1:0] rp_n [NQ];
  logic [NQ-1:0] chg, elig;
  logic [NF-1:0] ch_any;
  logic [FW-1:0] sel_ch;
  logic [QW-1:0] sel_q;

  function automatic logic [FW-1:0] prio_ch(input int k);
    return (k < NEDCA) ? FW'(NEDCA - 1 - k) : FW'(k);
  endfunction

  always_comb begin
    ch_any = '0;
    for (int q = 0; q < NQ; q++) begin
      elig[q] = st[q][0] && !empty[q] && (int'(st[q][4:1]) < NF) &&
                fact[st[q][1 +: FW]] && fifo_ready[st[q][1 +: FW]];
      if (elig[q]) ch_any[st[q][1 +: FW]] = 1'b1;
    end
    sel_ch = '0;
    for (int k = NF - 1; k >= 0; k--)
      if (ch_any[prio_ch(k)]) sel_ch = prio_ch(k);
  end

  always_comb begin
    logic hit;
    logic [QW-1:0] qi;
    hit = 1'b0;
    sel_q = '0;
    for (int i = 1; i <= NQ; i++) begin
      qi = last[sel_ch] + QW'(i);
      if (!hit && elig[qi] && st[qi][1 +: FW] == sel_ch) begin
        sel_q = qi;
        hit = 1'b1;
      end
    end
  end

  assign sel_valid = |ch_any;
  assign sel_queue = sel_q;
  assign sel_fifo  = sel_ch;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      logic hw, hr, gr;
      hw = wr_en && wr_addr == AW'(WP_BASE + q);
      hr = wr_en && wr_addr == AW'(RP_BASE + q);
      gr = sel_valid && sel_q == QW'(q);
      wp_n[q] = hw ? wr_data[PW-1:0] : wp[q];
      rp_n[q] = hr ? wr_data[PW-1:0] : (gr ? rp[q] + 1'b1 : rp[q]);
      chg[q]  = hw || hr || gr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NQ; q++) begin
        wp[q] <= '0;
        rp[q] <= '0;
        st[q] <= '0;
      end
      for (int c = 0; c < NF; c++) last[c] <= QW'(NQ - 1);
      fact  <= '0;
      chain <= '0;
      empty <= '1;
    end else begin
      for (int q = 0; q < NQ; q++) begin
        wp[q] <= wp_n[q];
        rp[q] <= rp_n[q];
        if (wr_en && wr_addr == AW'(ST_BASE + q))
          st[q] <= (st[q] & ~wr_data[SW +: SW]) | (wr_data[SW-1:0] & wr_data[SW +: SW]);
        if (chg[q])
          empty[q] <= (wp_n[q] == rp_n[q]);
        else if (wr_en && wr_addr == AW'(A_EMPTY) && wr_data[NQ + q])
          empty[q] <= wr_data[q];
      end
      if (wr_en && wr_addr == AW'(A_FACT))  fact  <= wr_data[NF-1:0];
      if (wr_en && wr_addr == AW'(A_CHAIN)) chain <= wr_data[NQ-1:0];
      if (sel_valid) last[sel_ch] <= sel_q;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int q = 0; q < NQ; q++) begin
      if (rd_addr == AW'(WP_BASE + q)) rd_data = DW'(wp[q]);
      if (rd_addr == AW'(RP_BASE + q)) rd_data = DW'(rp[q]);
      if (rd_addr == AW'(ST_BASE + q)) rd_data = DW'(st[q]);
    end
    if (rd_addr == AW'(A_FACT))  rd_data = DW'(fact);
    if (rd_addr == AW'(A_CHAIN)) rd_data = DW'(chain);
    if (rd_addr == AW'(A_EMPTY)) rd_data = DW'(empty);
  end

  assert_sel_queue_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> st[sel_queue][0] && !empty[sel_queue]);

  assert_sel_fifo_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> fact[sel_fifo] && fifo_ready[sel_fifo]);

  assert_fifo_off_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == AW'(A_FACT) && wr_data[NF-1:0] == '0) |=> !sel_valid);

  assert_grant_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !wr_en) |=> rp[$past(sel_queue)] == $past(rp[sel_queue]) + 1'b1);

  assert_empty_track_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_valid && !wr_en) |=>
      empty[$past(sel_queue)] == (wp[$past(sel_queue)] == rp[$past(sel_queue)]));
endmodule

// File: tb/sim_txq_sched_regs.sv
`timescale 1ns/1ps
module sim_txq_sched_regs;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [5:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [7:0] fifo_ready = 0;
  logic sel_valid;
  logic [3:0] sel_queue;
  logic [2:0] sel_fifo;
  int checks = 0, failures = 0;

  txq_sched_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fifo_ready(fifo_ready),
    .sel_valid(sel_valid), .sel_queue(sel_queue), .sel_fifo(sel_fifo));

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string tag, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  function automatic logic [31:0] stw(input logic [9:0] m, input logic [9:0] v);
    return {12'h0, m, v};
  endfunction

  task automatic grant_once(input string tag, input logic [3:0] q, input logic [2:0] f);
    @(negedge clk);
    fifo_ready = 8'hFF; #1;
    chk({tag, " valid"}, 32'(sel_valid), 1);
    chk({tag, " queue"}, 32'(sel_queue), 32'(q));
    chk({tag, " fifo"}, 32'(sel_fifo), 32'(f));
    @(negedge clk);
    fifo_ready = 0;
  endtask

  task automatic t_reset;
    rd("R1 wp0", 6'h00, 0);
    rd("R1 rp5", 6'h15, 0);
    rd("R1 st3", 6'h23, 0);
    rd("R1 fact", 6'h30, 0);
    rd("R1 chain", 6'h31, 0);
    rd("R1 empty", 6'h32, 32'hFFFF);
    fifo_ready = 8'hFF; #1;
    chk("R1 idle", 32'(sel_valid), 0);
    fifo_ready = 0;
  endtask

  task automatic t_ptrs;
    wr(6'h02, 32'hFFFF_FF05);
    rd("R2 wp2", 6'h02, 32'h05);
    rd("R5 empty after wp", 6'h32, 32'hFFFB);
    wr(6'h12, 32'h05);
    rd("R2 rp2", 6'h12, 32'h05);
    rd("R5 empty after rp", 6'h32, 32'hFFFF);
  endtask

  task automatic t_status;
    wr(6'h21, stw(10'h3FF, 10'h123));
    rd("R3 full write", 6'h21, 32'h123);
    wr(6'h21, stw(10'h001, 10'h000));
    rd("R3 masked bit0", 6'h21, 32'h122);
    wr(6'h21, 32'hFFF0_0000 | stw(10'h000, 10'h3FF));
    rd("R3 mask zero", 6'h21, 32'h122);
    wr(6'h21, stw(10'h3FF, 10'h000));
  endtask

  task automatic t_empty;
    wr(6'h32, 32'h0001_0000);
    rd("R4 clear bit0", 6'h32, 32'hFFFE);
    wr(6'h32, 32'h0000_0000);
    rd("R4 no mask", 6'h32, 32'hFFFE);
    wr(6'h32, 32'h0001_0001);
    rd("R4 set bit0", 6'h32, 32'hFFFF);
  endtask

  task automatic t_select;
    wr(6'h30, 32'hFF);
    wr(6'h23, stw(10'h3FF, 10'h003));
    wr(6'h03, 32'h02);
    grant_once("R6 q3 first", 4'd3, 3'd1);
    rd("R7 rp3 one", 6'h13, 32'h01);
    grant_once("R7 q3 second", 4'd3, 3'd1);
    rd("R7 rp3 two", 6'h13, 32'h02);
    rd("R5 q3 drained", 6'h32, 32'hFFFF);
  endtask

  task automatic t_inactive;
    wr(6'h24, stw(10'h3FE, 10'h000));
    wr(6'h04, 32'h01);
    rd("R6 inactive fields", 6'h24, 32'h000);
    @(negedge clk); fifo_ready = 8'hFF; #1;
    chk("R6 inactive not offered", 32'(sel_valid), 0);
    fifo_ready = 0;
    wr(6'h30, 32'hFE);
    wr(6'h24, stw(10'h001, 10'h001));
    @(negedge clk); fifo_ready = 8'hFF; #1;
    chk("R6 channel disabled", 32'(sel_valid), 0);
    fifo_ready = 0;
    wr(6'h30, 32'hFF);
    @(negedge clk); fifo_ready = 8'hFE; #1;
    chk("R6 channel not ready", 32'(sel_valid), 0);
    fifo_ready = 0;
    grant_once("R6 q4 served", 4'd4, 3'd0);
  endtask

  task automatic t_prio;
    wr(6'h25, stw(10'h3FF, 10'h001));
    wr(6'h26, stw(10'h3FF, 10'h005));
    wr(6'h27, stw(10'h3FF, 10'h009));
    wr(6'h28, stw(10'h3FF, 10'h007));
    for (int q = 5; q <= 8; q++) wr(6'(q), 32'h01);
    grant_once("R8 ch3 first", 4'd8, 3'd3);
    grant_once("R8 ch2 next", 4'd6, 3'd2);
    grant_once("R8 ch0 next", 4'd5, 3'd0);
    grant_once("R8 ch4 last", 4'd7, 3'd4);
  endtask

  task automatic t_rr;
    for (int q = 9; q <= 11; q++) begin
      wr(6'(6'h20 + q), stw(10'h3FF, 10'h005));
      wr(6'(q), 32'h02);
    end
    for (int r = 0; r < 2; r++) begin
      grant_once("R9 rr q9", 4'd9, 3'd2);
      grant_once("R9 rr q10", 4'd10, 3'd2);
      grant_once("R9 rr q11", 4'd11, 3'd2);
    end
  endtask

  task automatic t_chain;
    wr(6'h31, 32'hFFFF);
    rd("R10 chain readback", 6'h31, 32'hFFFF);
    wr(6'h2C, stw(10'h3FF, 10'h103));
    rd("R10 ack bit readback", 6'h2C, 32'h103);
    wr(6'h0C, 32'h03);
    @(negedge clk); fifo_ready = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R10 one per grant valid", 32'(sel_valid), 1);
      chk("R10 one per grant queue", 32'(sel_queue), 32'd12);
      @(negedge clk);
    end
    fifo_ready = 0;
    rd("R10 rp12 three", 6'h1C, 32'h03);
  endtask

  task automatic t_rp_wins;
    wr(6'h2D, stw(10'h3FF, 10'h003));
    wr(6'h0D, 32'h05);
    @(negedge clk);
    fifo_ready = 8'hFF; wr_en = 1; wr_addr = 6'h1D; wr_data = 32'h04;
    @(negedge clk);
    fifo_ready = 0; wr_en = 0;
    rd("R7 write beats grant", 6'h1D, 32'h04);
    grant_once("R7 q13 remaining", 4'd13, 3'd1);
    rd("R7 rp13 five", 6'h1D, 32'h05);
  endtask

  task automatic t_wrap;
    wr(6'h2E, stw(10'h3FF, 10'h001));
    wr(6'h1E, 32'hFF);
    grant_once("R7 wrap offer", 4'd14, 3'd0);
    rd("R7 rp14 wrapped", 6'h1E, 32'h00);
    rd("R5 q14 empty", 6'h32, 32'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_ptrs;
    t_status;
    t_empty;
    t_select;
    t_inactive;
    t_prio;
    t_rr;
    t_chain;
    t_rp_wins;
    t_wrap;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule